// File: doc/BRIEF.md
# Secure-Aware Private Interrupt Enable Bank

This block holds one forwarding-enable bit for each of the 32 private interrupts of a single CPU. Bits 15..0 cover software-generated interrupts and bits 31..16 cover private peripheral interrupts. The full enable vector leaves the block on `irq_enable` for the downstream forwarding logic.

Software reaches the bits through a small memory-mapped port with an address, write data, a write strobe, read data and a flag that marks the access as secure. Two aliases expose the same enable state:
- The clear alias at offset 0x180 disables every bit written as 1.
- The set alias at offset 0x100 enables every bit written as 1.

Reading either alias returns the current enables. Three controls decide, bit by bit, whether an access may see or change a bit:
- the per-bit security group (`grp_secure`),
- a global security-disable control,
- a routing-mode enable for each security state.

A bit that an access may not reach reads as 0, and a write to it has no effect.

Top module: `irq_enable_bank`

## Requirements
- R1: While `rst_n` is low, and after it is released with no write, `irq_enable` equals the parameter `RESET_VAL`.
- R2: A write to offset 0x180 clears every reachable bit whose `wdata` bit is 1. Bits written as 0 are left unchanged.
- R3: A write to offset 0x100 sets every reachable bit whose `wdata` bit is 1. Bits written as 0 are left unchanged.
- R4: While `addr` is 0x100 or 0x180, `rdata` equals `irq_enable` ANDed with the reachable-bit mask. At any other address `rdata` is 0.
- R5: For a non-secure access (`acc_secure`=0) with `sec_disable`=0, every bit whose `grp_secure` bit is 1 reads as 0 and ignores writes.
- R6: A secure access, or any access while `sec_disable`=1, may reach every bit, limited only by routing mode (R7).
- R7: A bit whose security state has routing mode off reads as 0 and ignores writes. Bit i uses `route_en_s` when `grp_secure[i]`=1 and `route_en_ns` when it is 0.
- R8: `rdata` is combinational. During a cycle with a write it returns the value from before that write, and the write takes effect at the next rising edge.
- R9: `irq_enable` always shows the whole enable vector, with no security or routing masking.
- R10: A write strobe at any address other than 0x100 or 0x180 leaves `irq_enable` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte offset within the register frame |
| wdata | input | 32 | Write data, one bit per interrupt |
| wr_en | input | 1 | Write strobe |
| acc_secure | input | 1 | 1 marks the current access as secure |
| rdata | output | 32 | Read data of the addressed alias |
| grp_secure | input | 32 | Per-interrupt security group, 1 = secure |
| sec_disable | input | 1 | 1 lets non-secure accesses reach secure-group bits |
| route_en_s | input | 1 | Routing mode enabled for the secure state |
| route_en_ns | input | 1 | Routing mode enabled for the non-secure state |
| irq_enable | output | 32 | Current forwarding enables |

## Verification
The assertions check the following on every clock cycle:
- A clear-alias write never raises a bit, and a set-alias write never lowers one.
- A write outside the aliases leaves the vector stable.
- Secure-group bits never change under a non-secure write while security is enabled.
- Bits whose routing mode is off never change.
- Read data never shows a bit that is not enabled, and it is zero away from the aliases.

Some behaviour only the bench scenarios can show, by comparing against a reference model:
- the reset pattern,
- that every reachable bit written as 1 actually changes,
- the exact read value under each combination of security flag, security disable and routing mode,
- that a read in the same cycle as a write returns the value from before the write.

// File: rtl/irq_en_pkg.sv
package irq_en_pkg;
  localparam int unsigned NUM_IRQ  = 32;
  localparam int unsigned ADDR_W   = 12;
  localparam logic [ADDR_W-1:0] SET_OFF = 12'h100;
  localparam logic [ADDR_W-1:0] CLR_OFF = 12'h180;
  typedef logic [NUM_IRQ-1:0] irq_vec_t;
endpackage

// File: rtl/irq_en_access_mask.sv
module irq_en_access_mask
  import irq_en_pkg::*;
#(
  parameter int unsigned N = NUM_IRQ
) (
  input  logic [N-1:0] grp_secure,
  input  logic         acc_secure,
  input  logic         sec_disable,
  input  logic         route_en_s,
  input  logic         route_en_ns,
  output logic [N-1:0] reach
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic route_ok;
    logic sec_ok;
    always_comb begin
      route_ok = grp_secure[i] ? route_en_s : route_en_ns;
      sec_ok   = acc_secure | sec_disable | ~grp_secure[i];
      reach[i] = route_ok & sec_ok;
    end
  end
endmodule

// File: rtl/irq_en_addr_decode.sv
module irq_en_addr_decode
  import irq_en_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic              sel_any,
  output logic              set_we,
  output logic              clr_we
);
  logic hit_set;
  logic hit_clr;
  always_comb begin
    hit_set = (addr == SET_OFF);
    hit_clr = (addr == CLR_OFF);
    sel_any = hit_set | hit_clr;
    set_we  = wr_en & hit_set;
    clr_we  = wr_en & hit_clr;
  end
endmodule

// File: rtl/irq_en_state.sv
module irq_en_state
  import irq_en_pkg::*;
#(
  parameter int unsigned N         = NUM_IRQ,
  parameter logic [N-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_bits,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] en_q
);
  logic [N-1:0] en_d;
  logic         en_ce;

  always_comb begin
    en_ce = |(set_bits | clr_bits);
    // clear has priority over set on the same bit
    en_d  = (en_q | set_bits) & ~clr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= RESET_VAL;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
  import irq_en_pkg::*;
#(
  parameter logic [31:0] RESET_VAL = 32'hA5A5_0F0F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  input  logic        wr_en,
  input  logic        acc_secure,
  output logic [31:0] rdata,
  input  logic [31:0] grp_secure,
  input  logic        sec_disable,
  input  logic        route_en_s,
  input  logic        route_en_ns,
  output logic [31:0] irq_enable
);
  irq_vec_t reach;
  irq_vec_t set_bits;
  irq_vec_t clr_bits;
  irq_vec_t en_q;
  logic     sel_any;
  logic     set_we;
  logic     clr_we;

  irq_en_access_mask #(.N(NUM_IRQ)) u_mask (
    .grp_secure (grp_secure),
    .acc_secure (acc_secure),
    .sec_disable(sec_disable),
    .route_en_s (route_en_s),
    .route_en_ns(route_en_ns),
    .reach      (reach)
  );

  irq_en_addr_decode u_dec (
    .addr   (addr),
    .wr_en  (wr_en),
    .sel_any(sel_any),
    .set_we (set_we),
    .clr_we (clr_we)
  );

  always_comb begin
    set_bits = set_we ? (wdata & reach) : '0;
    clr_bits = clr_we ? (wdata & reach) : '0;
    rdata    = sel_any ? (en_q & reach) : '0;
  end

  irq_en_state #(.N(NUM_IRQ), .RESET_VAL(RESET_VAL)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_bits(set_bits),
    .clr_bits(clr_bits),
    .en_q    (en_q)
  );

  assign irq_enable = en_q;
endmodule

// File: rtl/irq_enable_bank_chk.sv
module irq_enable_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] addr,
  input logic        wr_en,
  input logic        acc_secure,
  input logic [31:0] rdata,
  input logic [31:0] grp_secure,
  input logic        sec_disable,
  input logic        route_en_s,
  input logic        route_en_ns,
  input logic [31:0] irq_enable
);
  logic is_alias;
  logic [31:0] route_off;
  assign is_alias  = (addr == 12'h100) || (addr == 12'h180);
  assign route_off = (grp_secure & {32{~route_en_s}}) | (~grp_secure & {32{~route_en_ns}});

  // R2
  clr_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h180) |=> ((irq_enable & ~$past(irq_enable)) == 32'h0));

  // R3
  set_never_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h100) |=> (($past(irq_enable) & ~irq_enable) == 32'h0));

  // R10
  stray_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && is_alias) |=> $stable(irq_enable));

  // R5
  ns_secure_bits_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_secure && !sec_disable) |=>
      (((irq_enable ^ $past(irq_enable)) & $past(grp_secure)) == 32'h0));

  // R7
  route_off_bits_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((irq_enable ^ $past(irq_enable)) & $past(route_off)) == 32'h0));

  // R4
  rdata_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~irq_enable) == 32'h0);

  // R4
  rdata_off_alias_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_alias |-> (rdata == 32'h0));
endmodule

bind irq_enable_bank irq_enable_bank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .wr_en      (wr_en),
  .acc_secure (acc_secure),
  .rdata      (rdata),
  .grp_secure (grp_secure),
  .sec_disable(sec_disable),
  .route_en_s (route_en_s),
  .route_en_ns(route_en_ns),
  .irq_enable (irq_enable)
);

// File: tb/irq_enable_bank_bench.sv
module irq_enable_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_PAT = 32'hA5A5_0F0F;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic        wr_en;
  logic        acc_secure;
  logic [31:0] rdata;
  logic [31:0] grp_secure;
  logic        sec_disable;
  logic        route_en_s;
  logic        route_en_ns;
  logic [31:0] irq_enable;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_enable_bank #(.RESET_VAL(RST_PAT)) u_irq_enable_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .acc_secure(acc_secure), .rdata(rdata), .grp_secure(grp_secure),
    .sec_disable(sec_disable), .route_en_s(route_en_s), .route_en_ns(route_en_ns),
    .irq_enable(irq_enable)
  );

  function automatic logic [31:0] reach_of(logic [31:0] g, logic sec, logic sd, logic rs, logic rns);
    logic [31:0] r;
    for (int i = 0; i < 32; i++)
      r[i] = (g[i] ? rs : rns) & (sec | sd | ~g[i]);
    return r;
  endfunction

  function automatic logic [31:0] read_of(logic [11:0] a, logic [31:0] en, logic [31:0] r);
    return (a == 12'h100 || a == 12'h180) ? (en & r) : 32'h0;
  endfunction

  function automatic logic [31:0] next_of(logic [11:0] a, logic w, logic [31:0] d,
                                          logic [31:0] en, logic [31:0] r);
    if (w && a == 12'h100) return en | (d & r);
    if (w && a == 12'h180) return en & ~(d & r);
    return en;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // one access: drive at negedge, check read before the edge, state after it
  task automatic access(string req, logic [11:0] a, logic w, logic [31:0] d, logic sec,
                        logic [31:0] g, logic sd, logic rs, logic rns);
    logic [31:0] r;
    @(negedge clk);
    addr = a; wr_en = w; wdata = d; acc_secure = sec;
    grp_secure = g; sec_disable = sd; route_en_s = rs; route_en_ns = rns;
    r = reach_of(g, sec, sd, rs, rns);
    #1;
    check({req, " read(R4,R8)"}, rdata, read_of(a, model, r));
    model = next_of(a, w, d, model, r);
    @(posedge clk); #1;
    check({req, " state(R9)"}, irq_enable, model);
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; acc_secure = 1'b0;
    grp_secure = '0; sec_disable = 1'b0; route_en_s = 1'b1; route_en_ns = 1'b1;
    #(CLK_PERIOD*2 + 2);
    check("R1 in reset", irq_enable, RST_PAT);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", irq_enable, RST_PAT);
    model = RST_PAT;

    // R2 clear with write-0 bits untouched, all reachable
    access("R2 clear", 12'h180, 1, 32'h0000_00FF, 1, '0, 0, 1, 1);
    // R3 set
    access("R3 set", 12'h100, 1, 32'hF000_0000, 1, '0, 0, 1, 1);
    // R10 stray write
    access("R10 stray", 12'h080, 1, 32'hFFFF_FFFF, 1, '0, 0, 1, 1);
    // R5 non-secure, secure group upper half, security on
    access("R5 ns clear", 12'h180, 1, 32'hFFFF_FFFF, 0, 32'hFFFF_0000, 0, 1, 1);
    access("R5 ns set", 12'h100, 1, 32'hFFFF_FFFF, 0, 32'h0000_FFFF, 0, 1, 1);
    // R6 security disabled: ns reaches secure bits
    access("R6 sd clear", 12'h180, 1, 32'h00FF_FF00, 0, 32'hFFFF_FFFF, 1, 1, 1);
    access("R6 secure set", 12'h100, 1, 32'h0F0F_0F0F, 1, 32'hFFFF_0000, 0, 1, 1);
    // R7 routing off for secure state
    access("R7 route_s off", 12'h180, 1, 32'hFFFF_FFFF, 1, 32'hFF00_FF00, 0, 0, 1);
    access("R7 route_ns off", 12'h100, 1, 32'hFFFF_FFFF, 1, 32'hFF00_FF00, 0, 1, 0);
    // R8 read during write of clear alias returns pre-write
    access("R8 rd-during-wr", 12'h180, 1, 32'hFFFF_FFFF, 1, '0, 0, 1, 1);
    access("R4 read set alias", 12'h100, 0, 32'h0, 1, '0, 0, 1, 1);

    for (int k = 0; k < 400; k++) begin
      logic [11:0] a;
      case ($urandom_range(0, 3))
        0: a = 12'h100;
        1: a = 12'h180;
        2: a = 12'h17C;
        default: a = 12'($urandom);
      endcase
      access("rand R2/R3/R5/R6/R7/R10", a, 1'($urandom), $urandom, 1'($urandom),
             $urandom, 1'($urandom), 1'($urandom_range(0, 3) != 0),
             1'($urandom_range(0, 3) != 0));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule